// File: doc/BRIEF.md
# Nickel-Dime Vending Controller

This controller sits behind a coin acceptor that has already classified each inserted coin. It receives at most one coin event per clock, qualified by a valid strobe. It keeps the money credited so far as one of three amounts: 0, 5 or 10 cents. On every cycle it returns a two-bit action code that depends on the present credit and the incoming coin. That action is either no item, dispense or reject.

An item costs 15 cents. A coin that brings the total to 15 cents or more dispenses the item. Whatever exceeds the price stays as credit for the next purchase, so a dime on top of 10 cents dispenses and leaves 5 cents. A bad coin, which includes a quarter, is rejected and the credit is left as it was. The action output is Mealy: it changes in the same cycle as the coin that causes it. The credit changes on the following clock edge.

Top module: `vend_ctrl`

## Requirements
- R1: While reset (`rst_n` low, asynchronous) is asserted and in the first cycle after it, `credit` reads 00 (0 cents), and `action` reads 00 (no item) while `coin_vld` is low.
- R2: In a cycle with `coin_vld` low, `action` is 00 (no item) and `credit` keeps its value across the next clock edge.
- R3: A nickel (`coin_code` 00) moves the credit from 0 to 5 cents and from 5 to 10 cents with action 00. From 10 cents it dispenses (action 01) and the credit becomes 0.
- R4: A dime (`coin_code` 01) moves the credit from 0 to 10 cents with action 00. From 5 cents it dispenses (action 01) and the credit becomes 0. From 10 cents it dispenses (action 01) and 5 cents of credit remains.
- R5: A bad coin (`coin_code` 10) gives action 10 (reject) in its cycle and leaves the credit unchanged.
- R6: The undefined coin code 11 gives action 10 (reject) and clears the credit to 0 cents. The unused credit state 11, if it is ever reached, is left for 0 cents on the next edge with action 10.
- R7: `credit` is encoded as 00 = 0, 01 = 5 and 10 = 10 cents. `action` is encoded as 00 = no item, 01 = dispense and 10 = reject.
- R8: `credit` never shows the unused value 11, and a dispensing cycle never leaves 10 cents of credit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| coin_vld | input | 1 | A coin event is present this cycle |
| coin_code | input | 2 | Coin class: 00 nickel, 01 dime, 10 bad coin, 11 undefined |
| action | output | 2 | Per-cycle action: 00 no item, 01 dispense, 10 reject |
| credit | output | 2 | Registered credit: 00 0c, 01 5c, 10 10c |

## Verification
Directed sequences are applied first. Runs of nickels tell the 5-cent steps apart from the dispense at the third coin. Pairs of dimes expose whether the 5-cent excess is carried forward or dropped. Bad coins and undefined codes placed at each credit level tell a credit-preserving reject from a credit-clearing one. Idle gaps between coins show whether the credit holds without a strobe. A long pseudo-random stream of strobes and codes then reaches every pairing of credit and coin, in orders the directed part does not cover.

// File: rtl/vend_pkg.sv
package vend_pkg;
  localparam int COIN_W     = 2;
  localparam int CREDIT_W   = 2;
  localparam int ACT_W      = 2;
  localparam int PRICE_UNIT = 3;          // price in nickels
  localparam int SUM_W      = CREDIT_W + 1;

  typedef enum logic [COIN_W-1:0] {
    COIN_NICKEL = 2'b00,
    COIN_DIME   = 2'b01,
    COIN_BAD    = 2'b10,
    COIN_UNDEF  = 2'b11
  } coin_e;

  // credit encoding equals the credit counted in nickels
  typedef enum logic [CREDIT_W-1:0] {
    CR_0C    = 2'b00,
    CR_5C    = 2'b01,
    CR_10C   = 2'b10,
    CR_UNUSED = 2'b11
  } credit_e;

  typedef enum logic [ACT_W-1:0] {
    ACT_NONE   = 2'b00,
    ACT_VEND   = 2'b01,
    ACT_REJECT = 2'b10
  } act_e;

  // nickels a good coin is worth
  function automatic logic [CREDIT_W-1:0] coin_units(input coin_e c);
    return (c == COIN_DIME) ? CREDIT_W'(2) : CREDIT_W'(1);
  endfunction

  function automatic logic [SUM_W-1:0] units_sum(input logic [CREDIT_W-1:0] cr,
                                                 input logic [CREDIT_W-1:0] u);
    return SUM_W'(cr) + SUM_W'(u);
  endfunction

  function automatic logic price_met(input logic [SUM_W-1:0] s);
    return s >= SUM_W'(PRICE_UNIT);
  endfunction

  function automatic logic [CREDIT_W-1:0] carry_forward(input logic [SUM_W-1:0] s);
    logic [SUM_W-1:0] r;
    r = price_met(s) ? (s - SUM_W'(PRICE_UNIT)) : s;
    return r[CREDIT_W-1:0];
  endfunction
endpackage

// File: rtl/vend_coin_decode.sv
module vend_coin_decode
  import vend_pkg::*;
(
  input  logic [COIN_W-1:0]   code_i,
  output logic [CREDIT_W-1:0] units_o,
  output logic                good_o,
  output logic                bad_o,
  output logic                undef_o
);
  coin_e coin;
  assign coin    = coin_e'(code_i);
  assign good_o  = (coin == COIN_NICKEL) || (coin == COIN_DIME);
  assign bad_o   = (coin == COIN_BAD);
  assign undef_o = (coin == COIN_UNDEF);
  assign units_o = good_o ? coin_units(coin) : '0;

  // R7
  one_class_chk: assert final ($countones({good_o, bad_o, undef_o}) == 1 || $isunknown(code_i));
endmodule

// File: rtl/vend_credit_step.sv
module vend_credit_step
  import vend_pkg::*;
(
  input  logic [CREDIT_W-1:0] credit_i,
  input  logic                vld_i,
  input  logic [CREDIT_W-1:0] units_i,
  input  logic                good_i,
  input  logic                bad_i,
  input  logic                undef_i,
  output logic [CREDIT_W-1:0] credit_o,
  output logic [ACT_W-1:0]    action_o,
  output logic                vend_ev_o,
  output logic                reject_ev_o,
  output logic                recover_ev_o
);
  logic [SUM_W-1:0] sum;
  assign sum = units_sum(credit_i, units_i);

  always_comb begin
    credit_o     = credit_i;
    action_o     = ACT_NONE;
    vend_ev_o    = 1'b0;
    reject_ev_o  = 1'b0;
    recover_ev_o = 1'b0;
    if (credit_i == CR_UNUSED) begin
      credit_o     = CR_0C;
      action_o     = ACT_REJECT;
      recover_ev_o = 1'b1;
    end else if (vld_i) begin
      if (undef_i) begin
        credit_o     = CR_0C;
        action_o     = ACT_REJECT;
        recover_ev_o = 1'b1;
      end else if (bad_i) begin
        action_o     = ACT_REJECT;
        reject_ev_o  = 1'b1;
      end else if (good_i) begin
        credit_o  = carry_forward(sum);
        vend_ev_o = price_met(sum);
        action_o  = price_met(sum) ? ACT_VEND : ACT_NONE;
      end
    end
  end
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
  import vend_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                coin_vld,
  input  logic [COIN_W-1:0]   coin_code,
  output logic [ACT_W-1:0]    action,
  output logic [CREDIT_W-1:0] credit
);
  logic [CREDIT_W-1:0] credit_q, credit_d, units;
  logic coin_good, coin_bad, coin_undef;
  logic vend_ev, reject_ev, recover_ev;

  vend_coin_decode u_dec (
    .code_i (coin_code),
    .units_o(units),
    .good_o (coin_good),
    .bad_o  (coin_bad),
    .undef_o(coin_undef)
  );

  vend_credit_step u_step (
    .credit_i    (credit_q),
    .vld_i       (coin_vld),
    .units_i     (units),
    .good_i      (coin_good),
    .bad_i       (coin_bad),
    .undef_i     (coin_undef),
    .credit_o    (credit_d),
    .action_o    (action),
    .vend_ev_o   (vend_ev),
    .reject_ev_o (reject_ev),
    .recover_ev_o(recover_ev)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) credit_q <= CR_0C;
    else        credit_q <= credit_d;
  end

  assign credit = credit_q;

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!coin_vld && credit_q != CR_UNUSED) |=> credit_q == $past(credit_q));
  // R2
  idle_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!coin_vld && credit_q != CR_UNUSED) |-> action == ACT_NONE);
  // R5
  bad_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject_ev |=> credit_q == $past(credit_q));
  // R6
  recover_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recover_ev |=> credit_q == CR_0C);
  // R8
  no_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    credit_q != CR_UNUSED);
  // R8
  vend_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vend_ev |=> credit_q != CR_10C);
  // R7
  vend_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vend_ev |-> action == ACT_VEND);
endmodule

// File: tb/test_vend_ctrl.sv
`timescale 1ns/1ps
module test_vend_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic coin_vld = 1'b0;
  logic [1:0] coin_code = 2'b00;
  logic [1:0] action, credit;
  int n_vec = 0, n_bad = 0;
  int model_cents = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vend_ctrl i_vend_ctrl (
    .clk(clk), .rst_n(rst_n), .coin_vld(coin_vld),
    .coin_code(coin_code), .action(action), .credit(credit)
  );

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // apply one cycle of input and compare against the behavioural model
  task automatic apply(input bit vld, input logic [1:0] code);
    int exp_act, total;
    string tag;
    @(negedge clk);
    // R7 / R8: registered credit encodes cents/5 and is never 11
    check("R7", int'(credit), model_cents / 5);
    if (credit == 2'b11) check("R8", 3, 0);
    coin_vld  = vld;
    coin_code = code;
    #1;
    if (!vld) begin
      tag = "R2"; exp_act = 0;
    end else if (code == 2'b11) begin
      tag = "R6"; exp_act = 2; model_cents = 0;
    end else if (code == 2'b10) begin
      tag = "R5"; exp_act = 2;
    end else begin
      tag = (code == 2'b00) ? "R3" : "R4";
      total = model_cents + ((code == 2'b01) ? 10 : 5);
      if (total >= 15) begin
        exp_act = 1; model_cents = total - 15;
      end else begin
        exp_act = 0; model_cents = total;
      end
    end
    check(tag, int'(action), exp_act);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] lfsr;
    lfsr = 8'hA5;
    #1;
    // R1: in reset
    check("R1", int'(credit), 0);
    check("R1", int'(action), 0);
    #9;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(credit), 0);
    check("R1", int'(action), 0);
    // R2 idle
    apply(0, 2'b01); apply(0, 2'b11);
    // R3 nickels: 5, 10, vend -> 0
    apply(1, 2'b00); apply(0, 2'b00); apply(1, 2'b00); apply(1, 2'b00);
    // R4 dimes: 10, vend keeping 5, vend -> 0
    apply(1, 2'b01); apply(1, 2'b01); apply(1, 2'b01);
    // R5 bad coin at each level
    apply(1, 2'b10); apply(1, 2'b00); apply(1, 2'b10); apply(1, 2'b00);
    apply(1, 2'b10); apply(1, 2'b00);
    // R6 undefined code clears credit
    apply(1, 2'b01); apply(1, 2'b11); apply(1, 2'b00); apply(1, 2'b00);
    apply(1, 2'b11); apply(1, 2'b11);
    // random stream
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      apply(lfsr[0] | lfsr[4], (lfsr[3:1] == 3'b111) ? 2'b11 : {1'b0, lfsr[2]} | {lfsr[6] & lfsr[5], 1'b0});
    end
    apply(0, 2'b00);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule